// File: doc/BRIEF.md
# Burst Byte Lane Generator

This block walks a memory-mapped burst one beat at a time. For each beat it gives the beat address, the lowest and highest byte lanes the beat uses on a data bus of `BUS_BYTES` bytes, and a byte-enable mask that covers exactly those lanes. A request has a start address, a transfer size given as log2 of the bytes per beat, a beat count, and a burst kind: fixed, incrementing or wrapping. A single-cycle start pulse accepts the request.

After the start, the surrounding logic pulses `adv_i` once per beat to move to the next beat. The block marks the final beat and pulses `done_o` after that final beat is consumed. An unaligned first beat uses only the lanes from the start byte up to the end of its aligned transfer. Later beats of an incrementing burst are aligned. A wrapping burst folds back to its boundary. A request that cannot be carried out is refused with an error pulse.

Top module: `bl_lane_gen`

## Requirements
- R1: While `rst_n` is low on a clock edge, the block goes idle. After that edge `busy_o`, `last_o`, `done_o` and `err_o` are 0 and `strb_o` is all zeros. `strb_o` stays all zeros whenever `busy_o` is 0.
- R2: First-beat lane rule, which also applies to every beat of a fixed burst. Let n = 2^`size_i` and B = `BUS_BYTES`. `lo_lane_o` = start mod B. `hi_lane_o` = (start rounded down to a multiple of n) mod B + n − 1. `strb_o` bit i is 1 exactly when lo ≤ i ≤ hi.
- R3: For every beat after the first of an incrementing or wrapping burst, `lo_lane_o` = beat address mod B and `hi_lane_o` = `lo_lane_o` + n − 1. `strb_o` covers exactly those lanes.
- R4: For an incrementing burst (`burst_i` = 1), beat k (k ≥ 1, counted from 0) has address (start rounded down to a multiple of n) + k·n. Beat 0 has the start address.
- R5: For a wrapping burst (`burst_i` = 2), the boundary is the start rounded down to a multiple of n·L, where L = `len_i`+1 is the beat count. Each beat adds n to the address. An address that reaches boundary + n·L is replaced by the boundary.
- R6: For a fixed burst (`burst_i` = 0), every beat shows the start address.
- R7: A burst has `len_i`+1 beats (1 to 16). `last_o` is 1 only on the final beat. On the edge where `adv_i` is 1 on the final beat, the block goes idle and raises `done_o` for exactly one cycle.
- R8: While busy with `adv_i` low, the beat address and the beat position do not change.
- R9: A start pulse while `busy_o` is 1 has no effect on the burst in progress.
- R10: A request is refused in any of these cases: `size_i` > log2(B); `burst_i` = 3; a wrapping burst whose `len_i` is not 1, 3, 7 or 15; a wrapping burst whose start is not a multiple of n. On refusal `err_o` pulses for one cycle after the start edge and the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request pulse, accepted only while idle |
| addr_i | input | ADDR_W | Start address of the burst |
| size_i | input | 3 | log2 of bytes per beat |
| len_i | input | LEN_W | Beat count minus one |
| burst_i | input | 2 | Burst kind: 0 fixed, 1 incrementing, 2 wrapping, 3 reserved |
| adv_i | input | 1 | Consume the current beat |
| busy_o | output | 1 | A burst is in progress |
| addr_o | output | ADDR_W | Current beat address |
| lo_lane_o | output | log2(BUS_BYTES) | Lowest active byte lane |
| hi_lane_o | output | log2(BUS_BYTES) | Highest active byte lane |
| strb_o | output | BUS_BYTES | Byte-enable mask for the current beat |
| last_o | output | 1 | Current beat is the final one |
| done_o | output | 1 | One-cycle pulse after the final beat is consumed |
| err_o | output | 1 | One-cycle pulse for a refused request |

## Verification
The bench targets unaligned first beats of narrow and full-width transfers. A design that applied the later-beat rule there would switch on lanes past the end of the aligned transfer. Wrapping bursts are started mid-window so the fold back to the boundary is exercised; an off-by-one compare would leave the window or fold one beat early. Fixed bursts check that the address and the first-beat lanes repeat on every beat. Start pulses sent during a burst and stalled beats catch a design that reloads or drifts. Malformed wrap and size requests must produce an error pulse and no burst.

// File: rtl/bl_pkg.sv
package bl_pkg;
  typedef enum logic [1:0] {
    BT_FIXED = 2'd0,
    BT_INCR  = 2'd1,
    BT_WRAP  = 2'd2,
    BT_RSVD  = 2'd3
  } burst_e;
endpackage

// File: rtl/bl_lane_calc.sv
// Lane window and byte-enable mask for one beat.
module bl_lane_calc #(
  parameter int ADDR_W    = 32,
  parameter int BUS_BYTES = 8
) (
  input  logic [ADDR_W-1:0]              addr,
  input  logic [2:0]                     size,
  input  logic                           first_rule,
  input  logic                           en,
  output logic [$clog2(BUS_BYTES)-1:0]   lo,
  output logic [$clog2(BUS_BYTES)-1:0]   hi,
  output logic [BUS_BYTES-1:0]           strb
);
  localparam int LANE_W = $clog2(BUS_BYTES);

  // Lane offset of the start rounded down to the beat size.
  function automatic logic [LANE_W-1:0] f_size_floor(input logic [LANE_W-1:0] a,
                                                      input logic [2:0] sz);
    logic [LANE_W-1:0] keep;
    keep = '1;
    keep = keep << sz;
    return a & keep;
  endfunction

  // Highest lane: base + bytes-per-beat - 1.
  function automatic logic [LANE_W-1:0] f_top_lane(input logic [LANE_W-1:0] base,
                                                    input logic [2:0] sz);
    logic [LANE_W:0] nb;
    logic [LANE_W:0] sum;
    nb  = (LANE_W+1)'(1) << sz;
    sum = {1'b0, base} + nb - (LANE_W+1)'(1);
    return sum[LANE_W-1:0];
  endfunction

  logic [LANE_W-1:0] base;

  always_comb begin
    lo   = addr[LANE_W-1:0];
    base = first_rule ? f_size_floor(addr[LANE_W-1:0], size) : addr[LANE_W-1:0];
    hi   = f_top_lane(base, size);
  end

  for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
    assign strb[i] = en && (LANE_W'(i) >= lo) && (LANE_W'(i) <= hi);
  end
endmodule

// File: rtl/bl_addr_step.sv
// Address of the beat that follows the current one.
module bl_addr_step
  import bl_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [2:0]        size,
  input  burst_e            kind,
  input  logic [ADDR_W-1:0] bnd,
  input  logic [ADDR_W-1:0] span,
  output logic [ADDR_W-1:0] nxt,
  output logic              wrap_hit
);
  function automatic logic [ADDR_W-1:0] f_beat_bytes(input logic [2:0] sz);
    return ADDR_W'(1) << sz;
  endfunction

  logic [ADDR_W-1:0] nb;
  logic [ADDR_W-1:0] aligned;
  logic [ADDR_W-1:0] plain;

  always_comb begin
    nb       = f_beat_bytes(size);
    aligned  = cur & ~(nb - ADDR_W'(1));
    plain    = cur + nb;
    wrap_hit = (kind == BT_WRAP) && (plain == bnd + span);
    case (kind)
      BT_INCR: nxt = aligned + nb;
      BT_WRAP: nxt = wrap_hit ? bnd : plain;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/bl_lane_gen.sv
module bl_lane_gen
  import bl_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUS_BYTES = 8,
  parameter int LEN_W     = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [2:0]                    size_i,
  input  logic [LEN_W-1:0]              len_i,
  input  logic [1:0]                    burst_i,
  input  logic                          adv_i,
  output logic                          busy_o,
  output logic [ADDR_W-1:0]             addr_o,
  output logic [$clog2(BUS_BYTES)-1:0]  lo_lane_o,
  output logic [$clog2(BUS_BYTES)-1:0]  hi_lane_o,
  output logic [BUS_BYTES-1:0]          strb_o,
  output logic                          last_o,
  output logic                          done_o,
  output logic                          err_o
);
  localparam int LANE_W = $clog2(BUS_BYTES);

  logic              busy_q, first_q, done_q, err_q;
  logic [ADDR_W-1:0] addr_q, bnd_q, span_q;
  logic [2:0]        size_q;
  burst_e            kind_q;
  logic [LEN_W-1:0]  len_q, cnt_q;

  // Named events for the checker.
  logic start_take, beat_fire, is_last, burst_end, wrap_hit;
  logic [ADDR_W-1:0] nxt_addr;

  // Request decode.
  burst_e            req_kind;
  logic [ADDR_W-1:0] req_nb, req_span, req_bnd;
  logic              bad_size, bad_wrap, req_bad;

  always_comb begin
    req_kind = burst_e'(burst_i);
    req_nb   = ADDR_W'(1) << size_i;
    req_span = (ADDR_W'(len_i) + ADDR_W'(1)) << size_i;
    req_bnd  = addr_i & ~(req_span - ADDR_W'(1));
    bad_size = size_i > 3'(LANE_W);
    bad_wrap = (req_kind == BT_WRAP) &&
               ((len_i == '0) || ((len_i & (len_i + LEN_W'(1))) != '0) ||
                ((addr_i & (req_nb - ADDR_W'(1))) != '0));
    req_bad  = bad_size || bad_wrap || (req_kind == BT_RSVD);
  end

  assign start_take = start_i && !busy_q;
  assign beat_fire  = busy_q && adv_i;
  assign is_last    = busy_q && (cnt_q == len_q);
  assign burst_end  = beat_fire && is_last;

  bl_addr_step #(.ADDR_W(ADDR_W)) i_step (
    .cur      (addr_q),
    .size     (size_q),
    .kind     (kind_q),
    .bnd      (bnd_q),
    .span     (span_q),
    .nxt      (nxt_addr),
    .wrap_hit (wrap_hit)
  );

  bl_lane_calc #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) i_lanes (
    .addr       (addr_q),
    .size       (size_q),
    .first_rule (first_q || (kind_q == BT_FIXED)),
    .en         (busy_q),
    .lo         (lo_lane_o),
    .hi         (hi_lane_o),
    .strb       (strb_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      first_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      bnd_q   <= '0;
      span_q  <= '0;
      size_q  <= '0;
      kind_q  <= BT_FIXED;
      len_q   <= '0;
      cnt_q   <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (start_take) begin
        if (req_bad) begin
          err_q <= 1'b1;
        end else begin
          busy_q  <= 1'b1;
          first_q <= 1'b1;
          addr_q  <= addr_i;
          bnd_q   <= req_bnd;
          span_q  <= req_span;
          size_q  <= size_i;
          kind_q  <= req_kind;
          len_q   <= len_i;
          cnt_q   <= '0;
        end
      end else if (burst_end) begin
        busy_q  <= 1'b0;
        first_q <= 1'b0;
        done_q  <= 1'b1;
      end else if (beat_fire) begin
        first_q <= 1'b0;
        addr_q  <= nxt_addr;
        cnt_q   <= cnt_q + LEN_W'(1);
      end
    end
  end

  assign busy_o = busy_q;
  assign addr_o = addr_q;
  assign last_o = is_last;
  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/bl_lane_gen_chk.sv
module bl_lane_gen_chk #(
  parameter int ADDR_W    = 32,
  parameter int BUS_BYTES = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         start_i,
  input logic                         adv_i,
  input logic                         busy_o,
  input logic [ADDR_W-1:0]            addr_o,
  input logic [$clog2(BUS_BYTES)-1:0] lo_lane_o,
  input logic [$clog2(BUS_BYTES)-1:0] hi_lane_o,
  input logic [BUS_BYTES-1:0]         strb_o,
  input logic                         last_o,
  input logic                         done_o,
  input logic                         err_o,
  input logic                         beat_fire
);
  a_r1_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> strb_o == '0);

  a_r2_strobe_span: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (lo_lane_o <= hi_lane_o) &&
               ($countones(strb_o) == int'(hi_lane_o) - int'(lo_lane_o) + 1));

  a_r7_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(last_o && adv_i) && !busy_o);

  a_r8_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !beat_fire |=> busy_o && $stable(addr_o) && $stable(last_o));

  a_r9_start_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i && !adv_i |=> busy_o && $stable(addr_o) && !err_o);

  a_r10_err_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !busy_o && !done_o);
endmodule

bind bl_lane_gen bl_lane_gen_chk #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .adv_i     (adv_i),
  .busy_o    (busy_o),
  .addr_o    (addr_o),
  .lo_lane_o (lo_lane_o),
  .hi_lane_o (hi_lane_o),
  .strb_o    (strb_o),
  .last_o    (last_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .beat_fire (beat_fire)
);

// File: tb/test_bl_lane_gen.sv
`timescale 1ns/1ps
module test_bl_lane_gen;
  localparam int AW = 32;
  localparam int BB = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [2:0]    size_i = '0;
  logic [3:0]    len_i = '0;
  logic [1:0]    burst_i = '0;
  logic          adv_i = 1'b0;
  logic          busy_o, last_o, done_o, err_o;
  logic [AW-1:0] addr_o;
  logic [2:0]    lo_lane_o, hi_lane_o;
  logic [BB-1:0] strb_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bl_lane_gen #(.ADDR_W(AW), .BUS_BYTES(BB), .LEN_W(4)) i_bl_lane_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .size_i(size_i), .len_i(len_i), .burst_i(burst_i), .adv_i(adv_i),
    .busy_o(busy_o), .addr_o(addr_o), .lo_lane_o(lo_lane_o),
    .hi_lane_o(hi_lane_o), .strb_o(strb_o), .last_o(last_o),
    .done_o(done_o), .err_o(err_o)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [2:0]  size;
    logic [3:0]  len;
    logic [1:0]  kind;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1000, 3'd3, 4'd3,  2'd1},
    '{32'h0000_1003, 3'd2, 4'd3,  2'd1},
    '{32'h0000_1001, 3'd0, 4'd2,  2'd1},
    '{32'h0000_2005, 3'd3, 4'd1,  2'd1},
    '{32'h0000_3008, 3'd2, 4'd3,  2'd2},
    '{32'h0000_303C, 3'd2, 4'd7,  2'd2},
    '{32'h0000_4006, 3'd1, 4'd15, 2'd2},
    '{32'h0000_5003, 3'd2, 4'd2,  2'd0},
    '{32'h0000_6000, 3'd0, 4'd0,  2'd1},
    '{32'h0000_700E, 3'd1, 4'd1,  2'd2}
  };

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Bench model of beat k, written from the requirements.
  function automatic longint m_addr(input vec_t v, input int k);
    longint n, s, span, bnd, a;
    n = longint'(1) << v.size;
    s = longint'(v.addr);
    if (v.kind == 2'd0 || k == 0) return s;
    if (v.kind == 2'd1) return (s / n) * n + longint'(k) * n;
    span = n * (longint'(v.len) + 1);
    bnd = (s / span) * span;
    a = s;
    for (int j = 0; j < k; j++) begin
      a = a + n;
      if (a == bnd + span) a = bnd;
    end
    return a;
  endfunction

  task automatic lanes(input vec_t v, input int k, output int lo, output int hi);
    int n;
    longint a;
    n = 1 << v.size;
    a = m_addr(v, k);
    lo = int'(a % BB);
    if (k == 0 || v.kind == 2'd0)
      hi = int'(((longint'(v.addr) / n) * n) % BB) + n - 1;
    else
      hi = lo + n - 1;
  endtask

  function automatic longint m_mask(input int lo, input int hi);
    longint m = 0;
    for (int i = 0; i < BB; i++) if (i >= lo && i <= hi) m |= longint'(1) << i;
    return m;
  endfunction

  task automatic request(input vec_t v);
    @(negedge clk);
    start_i = 1'b1; addr_i = v.addr; size_i = v.size; len_i = v.len; burst_i = v.kind;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lo, hi, beats;
    vec_t v;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy_o, 0);
    chk("R1 strb", strb_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 err", err_o, 0);
    chk("R1 last", last_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R2 R3 R4 R5 R6 R7
    foreach (VECS[e]) begin
      v = VECS[e];
      beats = int'(v.len) + 1;
      adv_i = 1'b1;
      request(v);
      for (int k = 0; k < beats; k++) begin
        lanes(v, k, lo, hi);
        chk("R4/R5/R6 addr", addr_o, m_addr(v, k));
        chk(k == 0 ? "R2 lo" : "R3 lo", longint'(lo_lane_o), lo);
        chk(k == 0 ? "R2 hi" : "R3 hi", longint'(hi_lane_o), hi);
        chk(k == 0 ? "R2 strb" : "R3 strb", strb_o, m_mask(lo, hi));
        chk("R7 last", last_o, (k == beats - 1) ? 1 : 0);
        chk("R7 busy", busy_o, 1);
        if (k < beats - 1) chk("R7 done early", done_o, 0);
        @(negedge clk);
      end
      chk("R7 done", done_o, 1);
      chk("R7 idle", busy_o, 0);
      chk("R1 strb idle", strb_o, 0);
      adv_i = 1'b0;
      @(negedge clk);
      chk("R7 done one cycle", done_o, 0);
    end

    // R10 refused requests
    request('{32'h100, 3'd2, 4'd2, 2'd2});
    chk("R10 wrap len err", err_o, 1);
    chk("R10 wrap len idle", busy_o, 0);
    request('{32'h102, 3'd2, 4'd3, 2'd2});
    chk("R10 wrap unaligned err", err_o, 1);
    request('{32'h100, 3'd4, 4'd0, 2'd1});
    chk("R10 size err", err_o, 1);
    chk("R10 size idle", busy_o, 0);
    request('{32'h100, 3'd0, 4'd0, 2'd3});
    chk("R10 reserved err", err_o, 1);
    @(negedge clk);
    chk("R10 err one cycle", err_o, 0);

    // R8 stall and R9 start ignored
    adv_i = 1'b0;
    request('{32'h8000, 3'd2, 4'd3, 2'd1});
    chk("R8 first addr", addr_o, 32'h8000);
    @(negedge clk);
    chk("R8 held addr", addr_o, 32'h8000);
    chk("R8 held busy", busy_o, 1);
    start_i = 1'b1; addr_i = 32'h9001; size_i = 3'd0; len_i = 4'd0; burst_i = 2'd0;
    @(negedge clk);
    start_i = 1'b0;
    chk("R9 addr kept", addr_o, 32'h8000);
    chk("R9 size kept", longint'(hi_lane_o), 3);
    chk("R9 no err", err_o, 0);
    adv_i = 1'b1;
    @(negedge clk);
    chk("R4 step after stall", addr_o, 32'h8004);
    chk("R3 lanes after stall", strb_o, 8'hF0);
    repeat (3) @(negedge clk);
    chk("R7 done after stall", done_o, 1);
    adv_i = 1'b0;

    // R1 reset mid-burst
    request('{32'h200, 3'd3, 4'd5, 2'd1});
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset mid busy", busy_o, 0);
    chk("R1 reset mid strb", strb_o, 0);
    rst_n = 1'b1;

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule